// File: doc/BRIEF.md
# Framed Receive Packet Buffer

This block takes received Ethernet frames as a byte stream with a valid/ready handshake and an end-of-frame marker. It stores each frame in a byte-wide circular buffer inside a fixed framing. The framing is a constant marker word, then a length/status word, then the frame bytes, then zero fill up to the 60-byte minimum, then a CRC-32 frame check sequence, then zero fill to the next 4-byte boundary. Software drains the buffer one 32-bit word per read strobe. The block counts how many complete packets are held. A write of zero to the count register discards everything held. A status bit rises each time a packet becomes available.

The writer is a state machine. `W_IDLE` moves to `W_DATA` on the first accepted byte, or straight to `W_PAD` or `W_FCS` if that byte also ends the frame. `W_DATA` moves to `W_PAD` when the frame ends short of 60 bytes and to `W_FCS` when it ends at 60 bytes or more. It moves to `W_DROP` when a byte arrives beyond the maximum length. `W_PAD` moves to `W_FCS` once the length reaches 60. `W_FCS` moves to `W_ALIGN` when the write pointer is not word aligned, and to `W_HDR` when it is. `W_ALIGN` moves to `W_HDR` once the pointer is aligned. `W_HDR` back-fills the marker and header words, commits the packet and returns to `W_IDLE`. `W_DROP` returns to `W_IDLE` at the end of the oversize frame. A flush sends the writer to `W_DROP` if a frame is still arriving, and to `W_IDLE` otherwise.

The reader is a second state machine. `R_MAGIC` moves to `R_HDR` on a pop. `R_HDR` moves to `R_BODY` on a pop and loads the remaining body size. `R_BODY` returns to `R_MAGIC` when its last word is popped, and the packet count drops by one at that point.

Top module: `rx_frame_fifo`

## Requirements
- R1: `in_ready` can rise at a frame start only while `rx_en` is high and at least RESERVE bytes are free. RESERVE is 8 plus MAX_FRAME rounded up to a multiple of 4, plus 4 (1532 by default). Free space is DEPTH minus the bytes of committed, unread packets. `in_ready` stays high until the frame's last byte, and it is low while the packet is being finished.
- R2: Each stored packet is laid out as: marker word 32'hC0DE5A17; then a header word whose bits [31:16] are 16'h0001 (status OK) and whose bits [15:0] are the padded length plus 4; then the frame bytes; then zero bytes up to a 60-byte padded length; then the 4-byte check sequence; then zero bytes to a multiple of 4. Words are assembled least significant byte first.
- R3: The check sequence is the reflected CRC-32 with polynomial 32'hEDB88320. The register starts at all ones and runs over the frame bytes and any zero fill that brings the frame to 60 bytes. The complemented register is stored least significant byte first.
- R4: While `pkt_count` is non-zero, each `rd_req` returns the word at the buffer head on `rd_data` in the same cycle and advances the head. The first word of a packet is the marker and the second is the header. Then comes header[15:0] rounded up to a multiple of 4 bytes of body, and `pkt_count` drops by one after the last body word.
- R5: A `rd_req` while `pkt_count` is zero returns 0 and leaves the buffer head unchanged.
- R6: A `cnt_wr` with `cnt_wdata` equal to zero empties the buffer, clears the count and returns the reader to the start of a packet. A `cnt_wr` with any non-zero value has no effect.
- R7: `irq_rx` goes high in the cycle after a packet is committed. It stays high until an `irq_clr` pulse. A commit in the same cycle as a clear wins.
- R8: A frame longer than MAX_FRAME bytes (default 1518) is consumed to its end and discarded. It leaves no packet, no count change, no status and no stored bytes.
- R9: `pkt_count` equals the number of committed packets not yet fully read. Without a flush it changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| rd_req | input | 1 | Data register read strobe |
| rd_data | output | 32 | Data register read value |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 32 | Count register write value |
| pkt_count | output | CW | Count of held packets |
| irq_clr | input | 1 | Clears the receive status bit |
| irq_rx | output | 1 | Receive status bit |

## Verification
Frame lengths are chosen around the two boundaries that change the framing. Lengths of 1, 45, 59 and 60 all pad to the same 60-byte body. Lengths of 61 to 65 step the alignment fill through all four residues, and a longer frame checks the CRC over many bytes. Two maximum-length frames show the free-space gate closing and opening again. A frame one byte over the limit shows that dropping leaves no trace. A read on an empty buffer and a flush in the middle of a packet, each followed by a fresh packet, show that the head and the read position are where they should be.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [31:0] RXF_MAGIC     = 32'hC0DE_5A17;
    localparam logic [15:0] RXF_STATUS_OK = 16'h0001;
    localparam logic [31:0] RXF_CRC_POLY  = 32'hEDB8_8320;
    localparam int          RXF_MIN_FRAME = 60;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DATA,
        W_PAD,
        W_FCS,
        W_ALIGN,
        W_HDR,
        W_DROP
    } wr_state_e;

    typedef enum logic [1:0] {
        R_MAGIC,
        R_HDR,
        R_BODY
    } rd_state_e;

    // One byte through the reflected CRC-32, low bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in, input logic [7:0] data);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ RXF_CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= '1;
        else if (start) crc_q <= crc32_step(32'hFFFF_FFFF, din);
        else if (upd)   crc_q <= crc32_step(crc_q, din);
    end

endmodule

// File: rtl/rxf_byte_ram.sv
module rxf_byte_ram #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-3:0] rword_addr,
    output logic [31:0]   rword
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign rword[8*g +: 8] = store[{rword_addr, 2'(g)}];
    end

endmodule

// File: rtl/rxf_writer.sv
module rxf_writer
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 4096,
    parameter int MAX_FRAME = 1518,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1,
    localparam int RESERVE = 8 + ((MAX_FRAME + 3) / 4) * 4 + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          flush,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          commit,
    output logic [PW-1:0] commit_ptr
);

    wr_state_e     state_q, state_d;
    logic [PW-1:0] base_q, wptr_q;
    logic [15:0]   len_q;
    logic [2:0]    idx_q;
    logic [31:0]   crc_q;
    logic          crc_start, crc_upd;
    logic [PW-1:0] used, free;
    logic          acc, at_max, open_after;
    logic [PW-1:0] wptr_inc;
    logic [63:0]   head_bytes;
    logic [31:0]   fcs;

    assign used       = base_q - rd_ptr;
    assign free       = PW'(DEPTH) - used;
    assign acc        = in_valid && in_ready;
    assign at_max     = (len_q == 16'(MAX_FRAME));
    assign wptr_inc   = wptr_q + 1'b1;
    assign fcs        = ~crc_q;
    assign head_bytes = {RXF_STATUS_OK, len_q + 16'd4, RXF_MAGIC};
    assign commit_ptr = base_q;

    rxf_crc32 i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .upd   (crc_upd),
        .din   (mem_wdata),
        .crc_q (crc_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        open_after = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                if (acc) begin
                    if (!in_last)                   state_d = W_DATA;
                    else if (RXF_MIN_FRAME > 1)     state_d = W_PAD;
                    else                            state_d = W_FCS;
                end
                open_after = acc && !in_last;
            end
            W_DATA: begin
                if (acc) begin
                    if (at_max)                     state_d = in_last ? W_IDLE : W_DROP;
                    else if (in_last)
                        state_d = (len_q + 16'd1 < 16'(RXF_MIN_FRAME)) ? W_PAD : W_FCS;
                end
                open_after = !(acc && in_last);
            end
            W_PAD: begin
                if (len_q + 16'd1 == 16'(RXF_MIN_FRAME)) state_d = W_FCS;
            end
            W_FCS: begin
                if (idx_q == 3'd3) state_d = (wptr_inc[1:0] != 2'd0) ? W_ALIGN : W_HDR;
            end
            W_ALIGN: begin
                if (wptr_inc[1:0] == 2'd0) state_d = W_HDR;
            end
            W_HDR: begin
                if (idx_q == 3'd7) state_d = W_IDLE;
            end
            W_DROP: begin
                if (acc && in_last) state_d = W_IDLE;
                open_after = !(acc && in_last);
            end
            default: state_d = W_IDLE;
        endcase
        if (flush) state_d = open_after ? W_DROP : W_IDLE;
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = wptr_q[AW-1:0];
        mem_wdata = 8'h00;
        crc_start = 1'b0;
        crc_upd   = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                in_ready  = rx_en && (free >= PW'(RESERVE));
                mem_we    = acc;
                mem_addr  = AW'(base_q + PW'(8));
                mem_wdata = in_data;
                crc_start = acc;
            end
            W_DATA: begin
                in_ready  = 1'b1;
                mem_we    = acc && !at_max;
                mem_wdata = in_data;
                crc_upd   = acc && !at_max;
            end
            W_PAD: begin
                mem_we  = 1'b1;
                crc_upd = 1'b1;
            end
            W_FCS: begin
                mem_we    = 1'b1;
                mem_wdata = fcs[8*idx_q[1:0] +: 8];
            end
            W_ALIGN: begin
                mem_we = 1'b1;
            end
            W_HDR: begin
                mem_we    = 1'b1;
                mem_addr  = AW'(base_q + PW'(idx_q));
                mem_wdata = head_bytes[8*idx_q +: 8];
                commit    = (idx_q == 3'd7) && !flush;
            end
            W_DROP: begin
                in_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            base_q <= '0;
            wptr_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: if (acc) begin
                    wptr_q <= base_q + PW'(9);
                    len_q  <= 16'd1;
                    idx_q  <= '0;
                end
                W_DATA: if (acc && !at_max) begin
                    wptr_q <= wptr_inc;
                    len_q  <= len_q + 16'd1;
                end
                W_PAD: begin
                    wptr_q <= wptr_inc;
                    len_q  <= len_q + 16'd1;
                end
                W_FCS: begin
                    wptr_q <= wptr_inc;
                    idx_q  <= (idx_q == 3'd3) ? 3'd0 : idx_q + 3'd1;
                end
                W_ALIGN: wptr_q <= wptr_inc;
                W_HDR: begin
                    idx_q <= idx_q + 3'd1;
                    if (idx_q == 3'd7) base_q <= wptr_q;
                end
                default: ;
            endcase
        end
    end

    AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> (rx_en && free >= PW'(RESERVE))); // R1
    AST_PADDED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (len_q >= 16'(RXF_MIN_FRAME) && len_q <= 16'(MAX_FRAME))); // R2
    AST_FCS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_FCS && $past(state_q) == W_FCS) |-> $stable(crc_q)); // R3

endmodule

// File: rtl/rxf_reader.sv
module rxf_reader
    import rxf_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int CW    = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          flush,
    input  logic          commit,
    input  logic [31:0]   rword,
    output logic [31:0]   rd_data,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] pkt_count
);

    rd_state_e     state_q, state_d;
    logic [PW-1:0] rd_ptr_q;
    logic [15:0]   remain_q;
    logic [CW-1:0] pkt_q;
    logic          pop, last_pop;

    assign pop       = rd_req && (pkt_q != '0) && !flush;
    assign last_pop  = pop && (state_q == R_BODY) && (remain_q == 16'd4);
    assign rd_ptr    = rd_ptr_q;
    assign pkt_count = pkt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= R_MAGIC;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_MAGIC: if (pop) state_d = R_HDR;
            R_HDR:   if (pop) state_d = R_BODY;
            R_BODY:  if (last_pop) state_d = R_MAGIC;
            default: state_d = R_MAGIC;
        endcase
        if (flush) state_d = R_MAGIC;
    end

    // Outputs
    always_comb begin
        rd_data = (pkt_q != '0) ? rword : 32'h0;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr_q <= '0;
            remain_q <= '0;
            pkt_q    <= '0;
        end else begin
            if (pop) begin
                rd_ptr_q <= rd_ptr_q + PW'(4);
                unique case (state_q)
                    R_HDR:   remain_q <= (rword[15:0] + 16'd3) & 16'hFFFC;
                    R_BODY:  remain_q <= remain_q - 16'd4;
                    default: ;
                endcase
            end
            if (commit && !last_pop)      pkt_q <= pkt_q + 1'b1;
            else if (!commit && last_pop) pkt_q <= pkt_q - 1'b1;
        end
    end

    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && pkt_q == '0 && !flush) |=> $stable(rd_ptr_q)); // R5
    AST_MAGIC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q == R_MAGIC) |-> (rword == RXF_MAGIC)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (pkt_q == $past(pkt_q) || pkt_q == $past(pkt_q) + 1'b1
                    || pkt_q == $past(pkt_q) - 1'b1)); // R9
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pkt_q == '0 && rd_ptr_q == '0 && state_q == R_MAGIC)); // R6

endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 4096,
    parameter int MAX_FRAME = 1518,
    parameter int CW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          rd_req,
    output logic [31:0]   rd_data,
    input  logic          cnt_wr,
    input  logic [31:0]   cnt_wdata,
    output logic [CW-1:0] pkt_count,
    input  logic          irq_clr,
    output logic          irq_rx
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          flush, commit, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [PW-1:0] commit_ptr, rd_ptr;
    logic [31:0]   rword;

    assign flush = cnt_wr && (cnt_wdata == 32'h0);

    rxf_writer #(.DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME)) i_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .flush      (flush),
        .rd_ptr     (rd_ptr),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .commit     (commit),
        .commit_ptr (commit_ptr)
    );

    rxf_byte_ram #(.DEPTH(DEPTH)) i_ram (
        .clk        (clk),
        .we         (mem_we),
        .waddr      (mem_addr),
        .wdata      (mem_wdata),
        .rword_addr (rd_ptr[AW-1:2]),
        .rword      (rword)
    );

    rxf_reader #(.DEPTH(DEPTH), .CW(CW)) i_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .flush     (flush),
        .commit    (commit),
        .rword     (rword),
        .rd_data   (rd_data),
        .rd_ptr    (rd_ptr),
        .pkt_count (pkt_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       irq_rx <= 1'b0;
        else if (commit)  irq_rx <= 1'b1;
        else if (irq_clr) irq_rx <= 1'b0;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ptr - rd_ptr) <= PW'(DEPTH)); // R1
    AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> irq_rx); // R7

endmodule

// File: tb/test_rx_frame_fifo.sv
module test_rx_frame_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam logic [31:0] MAGIC = 32'hC0DE5A17;

    // {frame length, byte seed, expected header[15:0], expected word count}
    localparam int NVEC = 10;
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd1,   8'h11, 16'd64,  8'd18},
        {16'd45,  8'h3C, 16'd64,  8'd18},
        {16'd59,  8'hA0, 16'd64,  8'd18},
        {16'd60,  8'h05, 16'd64,  8'd18},
        {16'd61,  8'h77, 16'd65,  8'd19},
        {16'd62,  8'hE1, 16'd66,  8'd19},
        {16'd63,  8'h2B, 16'd67,  8'd19},
        {16'd64,  8'hFE, 16'd68,  8'd19},
        {16'd65,  8'h90, 16'd69,  8'd20},
        {16'd200, 8'h4D, 16'd204, 8'd53}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          rd_req = 1'b0;
    logic [31:0]   rd_data;
    logic          cnt_wr = 1'b0;
    logic [31:0]   cnt_wdata = 32'h0;
    logic [CW-1:0] pkt_count;
    logic          irq_clr = 1'b0;
    logic          irq_rx;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] eb [0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_fifo i_rx_frame_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .pkt_count (pkt_count),
        .irq_clr   (irq_clr),
        .irq_rx    (irq_rx)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    // Expected buffer image of one packet, from the layout requirements.
    function automatic int build(input int len, input logic [7:0] seed);
        int p, n;
        logic [31:0] c, hw;
        p = (len > 60) ? len : 60;
        hw = {16'h0001, 16'(p + 4)};
        for (int k = 0; k < 4; k++) begin
            eb[k]     = MAGIC[8*k +: 8];
            eb[4 + k] = hw[8*k +: 8];
        end
        c = 32'hFFFFFFFF;
        for (int i = 0; i < p; i++) begin
            logic [7:0] b;
            b = (i < len) ? fbyte(seed, i) : 8'h00;
            eb[8 + i] = b;
            c = c ^ {24'h0, b};
            for (int s = 0; s < 8; s++) c = (c >> 1) ^ (32'hEDB88320 & {32{c[0]}});
        end
        c = ~c;
        for (int k = 0; k < 4; k++) eb[8 + p + k] = c[8*k +: 8];
        n = 12 + p;
        while (n % 4 != 0) begin eb[n] = 8'h00; n++; end
        return n;
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        return {eb[4*k+3], eb[4*k+2], eb[4*k+1], eb[4*k]};
    endfunction

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            bit ok;
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbyte(seed, i);
            in_last  = (i == len - 1);
            ok = 1'b0;
            while (!ok) begin
                #1 ok = in_ready;
                @(posedge clk);
                if (!ok) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
        #1;
    endtask

    task automatic read_word(output logic [31:0] w);
        @(negedge clk);
        rd_req = 1'b1;
        #1 w = rd_data;
        @(posedge clk);
        #1 rd_req = 1'b0;
    endtask

    task automatic write_count(input logic [31:0] v);
        @(negedge clk);
        cnt_wr = 1'b1;
        cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
        #1;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        #1;
    endtask

    // Reads one whole packet and compares it with the model image.
    task automatic drain_check(input int len, input logic [7:0] seed, input int exp_hdr,
                               input int exp_words, input logic [CW-1:0] cnt_before);
        logic [31:0] w;
        int bad;
        logic [31:0] bad_act, bad_exp;
        void'(build(len, seed));
        read_word(w);
        check(w == MAGIC, "R2 marker word", w, MAGIC);
        read_word(w);
        check(w == {16'h0001, 16'(exp_hdr)}, "R2 header word", w, {16'h0001, 16'(exp_hdr)});
        bad = 0; bad_act = '0; bad_exp = '0;
        for (int k = 2; k < exp_words; k++) begin
            if (k == exp_words - 1)
                check(pkt_count == cnt_before, "R4 count held before last word", 32'(pkt_count), 32'(cnt_before));
            read_word(w);
            if (w != exp_word(k) && bad == 0) begin
                bad_act = w; bad_exp = exp_word(k);
            end
            if (w != exp_word(k)) bad++;
        end
        check(bad == 0, "R2 R3 body, fill and check sequence", bad_act, bad_exp);
        check(pkt_count == cnt_before - 1'b1, "R4 count after last word", 32'(pkt_count), 32'(cnt_before - 1'b1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // Reset state
        check(in_ready == 1'b0, "R1 ready low while disabled", 32'(in_ready), 32'h0);
        check(pkt_count == '0, "R9 count after reset", 32'(pkt_count), 32'h0);
        check(irq_rx == 1'b0, "R7 status after reset", 32'(irq_rx), 32'h0);
        check(rd_data == 32'h0, "R5 data on empty", rd_data, 32'h0);

        @(negedge clk);
        rx_en = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1 ready once enabled", 32'(in_ready), 32'h1);

        // Empty read must not move the head
        read_word(w);
        check(w == 32'h0, "R5 empty read value", w, 32'h0);
        send_frame(10, 8'h21);
        settle();
        check(pkt_count == 1, "R9 one packet held", 32'(pkt_count), 32'h1);
        read_word(w);
        check(w == MAGIC, "R5 head unmoved by empty read", w, MAGIC);

        // Flush in the middle of a packet
        write_count(32'h0);
        check(pkt_count == '0, "R6 flush clears count", 32'(pkt_count), 32'h0);
        read_word(w);
        check(w == 32'h0, "R6 read after flush", w, 32'h0);
        send_frame(1, 8'h11);
        settle();
        drain_check(1, 8'h11, 64, 18, 1);

        // Non-zero count write is ignored
        send_frame(20, 8'h66);
        settle();
        write_count(32'h5);
        check(pkt_count == 1, "R6 non-zero write ignored", 32'(pkt_count), 32'h1);
        drain_check(20, 8'h66, 64, 18, 1);

        // Status bit and its clear
        check(irq_rx == 1'b1, "R7 status set by packet", 32'(irq_rx), 32'h1);
        clear_irq();
        check(irq_rx == 1'b0, "R7 status cleared", 32'(irq_rx), 32'h0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            int L, H, N;
            logic [7:0] s;
            L = int'(VEC[v][47:32]);
            s = VEC[v][31:24];
            H = int'(VEC[v][23:8]);
            N = int'(VEC[v][7:0]);
            send_frame(L, s);
            settle();
            check(pkt_count == 1, "R9 count after frame", 32'(pkt_count), 32'h1);
            check(irq_rx == 1'b1, "R7 status after frame", 32'(irq_rx), 32'h1);
            drain_check(L, s, H, N, 1);
            clear_irq();
        end

        // Free-space gate with two maximum frames
        send_frame(1518, 8'h01);
        settle();
        check(in_ready == 1'b1, "R1 room for a second frame", 32'(in_ready), 32'h1);
        send_frame(1518, 8'h02);
        settle();
        check(pkt_count == 2, "R9 two packets held", 32'(pkt_count), 32'h2);
        check(in_ready == 1'b0, "R1 ready low when short of room", 32'(in_ready), 32'h0);
        drain_check(1518, 8'h01, 1522, 383, 2);
        check(in_ready == 1'b1, "R1 ready back after drain", 32'(in_ready), 32'h1);
        drain_check(1518, 8'h02, 1522, 383, 1);
        clear_irq();

        // Oversize frame is dropped without trace
        send_frame(1519, 8'h33);
        settle();
        check(pkt_count == '0, "R8 oversize frame not counted", 32'(pkt_count), 32'h0);
        check(irq_rx == 1'b0, "R8 oversize frame raises no status", 32'(irq_rx), 32'h0);
        read_word(w);
        check(w == 32'h0, "R8 nothing readable after drop", w, 32'h0);
        send_frame(30, 8'h5A);
        settle();
        drain_check(30, 8'h5A, 64, 18, 1);

        // Disable gates a new frame
        @(negedge clk);
        rx_en = 1'b0;
        #1;
        check(in_ready == 1'b0, "R1 ready low after disable", 32'(in_ready), 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule